// File: doc/BRIEF.md
# Scanline-Prescaled Interrupt Timer

This block is an interrupt timer for a cartridge that runs from the CPU clock. The timer has no video timing input, so it builds an approximate line period from the CPU clock. A prescaler gains three units on every CPU cycle. Each time it passes 341 units it emits one line tick. An 8-bit up-counter counts those ticks. When the counter wraps past 0xFF it raises a level interrupt request and reloads itself from an 8-bit reload value.

Software sets the timer with three CPU writes. Two writes each place one nibble of the reload value. The third write restarts the timer: it clears the prescaler, copies the reload value into the counter and sets or clears the run flag. Any of these three writes also clears a pending request. A typical driver loads the reload value, writes the restart with the run bit set, and acknowledges each request in its handler. The counter keeps running after each wrap.

Top module: `sirq_timer`

## Requirements
- R1: The decode compares `cpu_addr & 16'hF00C` with a fixed value. A write that decodes to 0xF000 copies `cpu_data[3:0]` into reload bits 3:0 and leaves reload bits 7:4 unchanged. Data bits 7:4 are ignored.
- R2: A write that decodes to 0xF004 copies `cpu_data[3:0]` into reload bits 7:4 and leaves reload bits 3:0 unchanged.
- R3: A write that decodes to 0xF008 clears the prescaler, loads the counter from the reload value and sets the run flag from `cpu_data[1]`. This restart also applies while the timer is already counting.
- R4: A write that decodes to any of 0xF000, 0xF004 or 0xF008 drives `irq` low from the next cycle, unless a wrap happens in the same cycle.
- R5: While running, the prescaler gains 3 per cycle. When the sum reaches 341 or more, 341 is subtracted and the counter increments. With reload value L, `irq` is first high exactly ceil((256-L)*341/3) clock edges after the restart edge.
- R6: An increment from 0xFF sets `irq` and reloads the counter from the reload value. If a wrap and an acknowledge fall in the same cycle, the wrap wins.
- R7: Once set, `irq` stays high until an acknowledging write or reset.
- R8: While the run flag is 0, neither the prescaler nor the counter changes, and `irq` never rises.
- R9: Counting continues after a wrap. The second rise after a restart comes ceil(2*(256-L)*341/3) edges after the restart edge.
- R10: Address bits outside the mask 0xF00C are ignored. A write whose masked address is none of the three values has no effect.
- R11: Asynchronous active-low reset clears the reload value, counter, prescaler, run flag and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, one cycle per write |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The bench measures the exact edge count to the first wrap and to the second wrap for several reload values, including 0. A prescaler off by one unit, or one that drops its remainder, would shift these counts by one or more cycles.

Nibble writes that carry junk in the upper data bits, and aliased or near-miss addresses, catch a decode that uses the wrong mask or a nibble write that disturbs the other half. A restart in the middle of a count catches a prescaler that is not cleared on restart.

A random phase with a short reload period checks the design cycle by cycle against a reference model. This phase makes acknowledges coincide with wraps, so a design that lets the acknowledge win, or that reloads from the wrong value, shows up.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_LO   = 2'd1,
    HIT_HI   = 2'd2,
    HIT_CTRL = 2'd3
  } reg_hit_e;

  // prescaler sum before the wrap test
  function automatic int unsigned pre_sum(input int unsigned q, input int unsigned step);
    return q + step;
  endfunction

  function automatic logic pre_wraps(input int unsigned sum, input int unsigned period);
    return sum >= period;
  endfunction

  // at most one subtraction is needed because step < period
  function automatic int unsigned pre_fold(input int unsigned sum, input int unsigned period);
    return (sum >= period) ? sum - period : sum;
  endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MASK  = 16'hF00C,
  parameter logic [ADDR_W-1:0] LO_A  = 16'hF000,
  parameter logic [ADDR_W-1:0] HI_A  = 16'hF004,
  parameter logic [ADDR_W-1:0] CTL_A = 16'hF008
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_e          hit
);
  logic [ADDR_W-1:0] key;

  always_comb begin
    key = addr & MASK;
    hit = HIT_NONE;
    if (we) begin
      if (key == LO_A)       hit = HIT_LO;
      else if (key == HI_A)  hit = HIT_HI;
      else if (key == CTL_A) hit = HIT_CTRL;
    end
  end
endmodule

// File: rtl/irq_prescaler.sv
module irq_prescaler
  import sirq_pkg::*;
#(
  parameter int PRE_W  = 9,
  parameter int STEP   = 3,
  parameter int PERIOD = 341
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  output logic [PRE_W-1:0] q,
  output logic             tick
);
  int unsigned       sum;
  logic              wrap;
  logic [PRE_W-1:0]  q_n;

  always_comb begin
    sum  = pre_sum({{(32-PRE_W){1'b0}}, q}, STEP);
    wrap = pre_wraps(sum, PERIOD);
    q_n  = PRE_W'(pre_fold(sum, PERIOD));
    tick = run & ~clear & wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clear) q <= '0;
    else if (run)   q <= q_n;
  end
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter
  import sirq_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int HALF = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_hit_e         hit,
  input  logic [HALF-1:0]  nib,
  input  logic             run_bit,
  input  logic             tick,
  output logic             irq,
  output logic             run_en,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W:0]   inc;
  logic             ack;

  always_comb begin
    inc  = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};
    fire = tick & inc[CNT_W];
    ack  = (hit != HIT_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
      count  <= '0;
      run_en <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (hit == HIT_LO) reload[HALF-1:0]     <= nib;
      if (hit == HIT_HI) reload[CNT_W-1:HALF] <= nib;
      if (hit == HIT_CTRL) begin
        count  <= reload;
        run_en <= run_bit;
      end else if (tick) begin
        count  <= inc[CNT_W] ? reload : inc[CNT_W-1:0];
      end
      if (fire)     irq <= 1'b1;
      else if (ack) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/sirq_timer.sv
module sirq_timer
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 9,
  parameter int STEP   = 3,
  parameter int PERIOD = 341,
  parameter int RUN_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_we,
  output logic              irq
);
  localparam int HALF = CNT_W / 2;

  reg_hit_e         hit;
  logic             ack_hit;
  logic             ctrl_hit;
  logic             pre_tick;
  logic             ovf_fire;
  logic             run_en;
  logic [PRE_W-1:0] prescale_q;
  logic [CNT_W-1:0] count_q;

  assign ack_hit  = (hit != HIT_NONE);
  assign ctrl_hit = (hit == HIT_CTRL);

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .we   (cpu_we),
    .addr (cpu_addr),
    .hit  (hit)
  );

  irq_prescaler #(.PRE_W(PRE_W), .STEP(STEP), .PERIOD(PERIOD)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ctrl_hit),
    .run   (run_en),
    .q     (prescale_q),
    .tick  (pre_tick)
  );

  irq_line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .nib     (cpu_data[HALF-1:0]),
    .run_bit (cpu_data[RUN_BIT]),
    .tick    (pre_tick),
    .irq     (irq),
    .run_en  (run_en),
    .count   (count_q),
    .fire    (ovf_fire)
  );
endmodule

// File: rtl/sirq_timer_chk.sv
module sirq_timer_chk #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 9,
  parameter int PERIOD = 341
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             ack_hit,
  input logic             ctrl_hit,
  input logic             ovf_fire,
  input logic             run_en,
  input logic [PRE_W-1:0] prescale_q,
  input logic [CNT_W-1:0] count_q
);
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !ovf_fire) |=> !irq);

  p_wrap_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_fire |=> irq);

  p_irq_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_hit) |=> irq);

  p_idle_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !ctrl_hit) |=> ($stable(count_q) && $stable(prescale_q)));

  p_idle_nofire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !ovf_fire);

  p_restart_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> (prescale_q == '0));

  p_pre_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(prescale_q) < PERIOD);
endmodule

bind sirq_timer sirq_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PERIOD(PERIOD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .ack_hit    (ack_hit),
  .ctrl_hit   (ctrl_hit),
  .ovf_fire   (ovf_fire),
  .run_en     (run_en),
  .prescale_q (prescale_q),
  .count_q    (count_q)
);

// File: tb/sim_sirq_timer.sv
module sim_sirq_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_we = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  bit cmp_on = 0;
  int edges = 0;

  // reference state
  int m_lat, m_cnt, m_pre;
  bit m_en, m_irq;

  sirq_timer u0 (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
                 .cpu_data(cpu_data), .cpu_we(cpu_we), .irq(irq));

  always #4 clk = ~clk;

  function automatic int fire_edges(input int lat, input int k);
    return (k * (256 - lat) * 341 + 2) / 3;
  endfunction

  function automatic int sel(input logic [15:0] a);
    return int'(a & 16'hF00C);
  endfunction

  always @(posedge clk) begin
    if (cpu_we && sel(cpu_addr) == 'hF008) edges <= 0;
    else edges <= edges + 1;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat = 0; m_cnt = 0; m_pre = 0; m_en = 0; m_irq = 0;
    end else begin
      bit acked, fired;
      int s;
      s = sel(cpu_addr);
      acked = cpu_we && (s == 'hF000 || s == 'hF004 || s == 'hF008);
      fired = 0;
      if (cpu_we && s == 'hF008) begin
        m_pre = 0; m_cnt = m_lat; m_en = cpu_data[1];
      end else if (m_en) begin
        m_pre = m_pre + 3;
        if (m_pre >= 341) begin
          m_pre = m_pre - 341;
          if (m_cnt == 255) begin fired = 1; m_cnt = m_lat; end
          else m_cnt = m_cnt + 1;
        end
      end
      if (cpu_we && s == 'hF000) m_lat = (m_lat & 'hF0) | int'(cpu_data[3:0]);
      if (cpu_we && s == 'hF004) m_lat = (m_lat & 'h0F) | (int'(cpu_data[3:0]) << 4);
      if (fired) m_irq = 1;
      else if (acked) m_irq = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    int k = 0;
    while (!irq && k < 70000) begin @(negedge clk); k++; end
    n = edges;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (cmp_on) chk(irq == m_irq, "R6 model", int'(irq), int'(m_irq));
  end

  initial begin
    int n;
    idle(3);
    chk(irq == 1'b0, "R11 reset", int'(irq), 0);
    rst_n = 1'b1;
    idle(2);

    // R1/R2/R5 first wrap timing with reload 0xF5
    wr(16'hF000, 8'h05);
    wr(16'hF004, 8'h0F);
    wr(16'hF008, 8'h02);
    wait_irq(n);
    chk(n == fire_edges('hF5, 1), "R5 first wrap", n, fire_edges('hF5, 1));
    // R7 holds
    idle(50);
    chk(irq == 1'b1, "R7 hold", int'(irq), 1);
    // R4 ack via low-nibble address, same nibble
    wr(16'hF000, 8'h05);
    chk(irq == 1'b0, "R4 ack F000", int'(irq), 0);
    // R9 second wrap continues from same restart
    wait_irq(n);
    chk(n == fire_edges('hF5, 2), "R9 second wrap", n, fire_edges('hF5, 2));
    // R4 ack via high-nibble address
    wr(16'hF004, 8'h0F);
    chk(irq == 1'b0, "R4 ack F004", int'(irq), 0);
    // R4 ack via control, R8 disabled
    wait_irq(n);
    wr(16'hF008, 8'h00);
    chk(irq == 1'b0, "R4 ack F008", int'(irq), 0);
    idle(3000);
    chk(irq == 1'b0, "R8 stopped", int'(irq), 0);

    // R10 near-miss addresses ignored, aliased address acks
    wr(16'hF008, 8'hFF);
    wait_irq(n);
    wr(16'hF00C, 8'h00);
    wr(16'h8000, 8'h00);
    wr(16'hE008, 8'h00);
    chk(irq == 1'b1, "R10 ignored", int'(irq), 1);
    wr(16'hFFF1, 8'h05);
    chk(irq == 1'b0, "R10 alias ack", int'(irq), 0);

    // R1 low nibble only, upper data bits ignored
    wr(16'hF000, 8'hA8);
    wr(16'hF008, 8'h02);
    wait_irq(n);
    chk(n == fire_edges('hF8, 1), "R1 low nibble", n, fire_edges('hF8, 1));
    // R2 high nibble only
    wr(16'hF004, 8'h3E);
    wr(16'hF008, 8'h02);
    wait_irq(n);
    chk(n == fire_edges('hE8, 1), "R2 high nibble", n, fire_edges('hE8, 1));
    // R3 restart mid-count
    wr(16'hF008, 8'h02);
    idle(1000);
    wr(16'hF008, 8'h02);
    wait_irq(n);
    chk(n == fire_edges('hE8, 1), "R3 restart", n, fire_edges('hE8, 1));

    // R11 reset mid-count clears reload value
    idle(20);
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    chk(irq == 1'b0, "R11 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    wr(16'hF008, 8'h02);
    wait_irq(n);
    chk(n == fire_edges(0, 1), "R11 reload cleared", n, fire_edges(0, 1));

    // random phase against reference model (R6 ack/wrap collisions)
    void'($urandom(32'h5EED1234));
    wr(16'hF004, 8'h0F);
    wr(16'hF000, 8'h0E);
    wr(16'hF008, 8'h02);
    cmp_on = 1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      cpu_we = 1'b0;
      if (($urandom() & 15) == 0) begin
        int pick = $urandom() % 6;
        logic [15:0] junk = 16'($urandom()) & 16'h0FF3;
        cpu_data = 8'($urandom());
        case (pick)
          0: cpu_addr = 16'hF000 | junk;
          1: begin cpu_addr = 16'hF004 | junk; cpu_data[3:0] = 4'hF; end
          2: begin cpu_addr = 16'hF008 | junk; cpu_data[1] = ($urandom() % 5) != 0; end
          3: cpu_addr = 16'hF00C | junk;
          4: cpu_addr = 16'h8000 | junk;
          default: cpu_addr = 16'($urandom());
        endcase
        cpu_we = 1'b1;
      end
    end
    @(negedge clk);
    cpu_we = 1'b0;
    cmp_on = 0;

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule